// File: doc/BRIEF.md
# TDM Clock and Frame Validity Monitor

This block watches the bit clock and frame pulse that one master drives onto a TDM backplane and decides whether the pair can still be trusted. A fast local clock samples both inputs through synchronizers. The block times the spacing between successive rising edges of the bit clock against a nominal interval and a tolerance window. It also counts bit-clock cycles between frame pulses and compares the count with the exact frame length.

The nominal bit-clock interval is 122 ns and the allowed deviation is 35 ns either way. The frame length is 1024 bit cycles. With a 100 MHz sampler the defaults are a 12-tick nominal interval and a 3-tick tolerance. A system with two backplane masters uses one instance per bus. The monitor runs all the time, whether or not anything downstream acts on its flags. Separate sticky flags record clock faults and frame faults, and each flag has its own clear pulse. A combined flag marks the pair as bad. A live validity output drops at once on any fault and returns only after a full, clean frame.

Top module: `tdm_pair_monitor`

## Requirements
- R1: After reset, clk_err, frm_err, pair_bad and pair_valid are all 0.
- R2: No error is flagged until the first frame pulse has been seen, whatever the bit clock does before it. The partial frame ending at that first pulse is not judged.
- R3: A synchronized bit-clock rising edge whose distance from the previous rising edge lies outside [NOM_TICKS-TOL_TICKS, NOM_TICKS+TOL_TICKS] sampler cycles sets clk_err. A 122 ns interval lies inside the window.
- R4: If no rising edge arrives within NOM_TICKS+TOL_TICKS sampler cycles of the previous one, clk_err is set (stopped clock). Checking resumes from the next edge.
- R5: A frame pulse (rising edge of the active level of fsync_in, active high by default) that arrives after fewer than FRAME_CYCLES bit-clock rising edges sets frm_err. That pulse then starts a new frame.
- R6: If a bit-clock rising edge would make the count exceed FRAME_CYCLES without a frame pulse, frm_err is set. Frame checking then resumes from the next pulse.
- R7: clk_err and frm_err stay set until their own clear input is high at a clock edge. Clearing one leaves the other unchanged. A new fault in the same cycle wins over the clear.
- R8: pair_bad is high exactly when clk_err or frm_err is high.
- R9: pair_valid rises only at the end of a frame that held exactly FRAME_CYCLES bit-clock edges with no clock fault. After reset this first happens at the second frame pulse.
- R10: pair_valid falls in the cycle that a clock or frame fault is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Bus bit clock, asynchronous |
| fsync_in | input | 1 | Bus frame pulse, asynchronous |
| clr_clk_err | input | 1 | Clears the sticky clock-fault flag |
| clr_frm_err | input | 1 | Clears the sticky frame-fault flag |
| clk_err | output | 1 | Sticky clock-fault flag |
| frm_err | output | 1 | Sticky frame-fault flag |
| pair_bad | output | 1 | Clock/frame pair marked invalid |
| pair_valid | output | 1 | Pair currently trusted |

## Verification
The assertions assume three things about the inputs. Each clear input is a short pulse. The frame pulse is wide enough to survive synchronization. Each input level lasts several sampler cycles, so that every synchronized edge is a single-cycle event. The stimulus meets these assumptions in four ways. It changes both bus inputs only at half-nanosecond offsets, which never coincide with a sampler edge. It keeps every bit-clock phase at least 30 ns long. It holds the frame pulse high for a whole bit cycle. It drives each clear for exactly one sampler cycle. Faulty intervals are chosen well clear of the window limits, so a single tick of synchronizer jitter cannot change the verdict.

// File: rtl/tdm_mon_pkg.sv
package tdm_mon_pkg;

   // Per-cycle events produced by the two checkers
   typedef struct packed {
      logic clk_fault;
      logic frm_fault;
      logic frm_good;
   } mon_ev_t;

   // Bits needed to hold values 0..max_val
   function automatic int bits_for(input int max_val);
      int n;
      n = 1;
      while ((1 << n) <= max_val) n++;
      return n;
   endfunction

endpackage

// File: rtl/tdm_sync_rise.sv
module tdm_sync_rise #(
   parameter int               STAGES = 2,
   parameter int               WIDTH  = 2,
   parameter logic [WIDTH-1:0] INVERT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tdm_sync_rise: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic              lvl;
      logic [STAGES-1:0] sh;
      logic              last;

      // Polarity variant picked at elaboration
      if (INVERT[b]) begin : g_inv
         assign lvl = ~din[b];
      end else begin : g_pass
         assign lvl = din[b];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh   <= '0;
            last <= 1'b0;
         end else begin
            sh   <= {sh[STAGES-2:0], lvl};
            last <= sh[STAGES-1];
         end
      end

      assign rise[b] = sh[STAGES-1] & ~last;
   end

endmodule

// File: rtl/tdm_bclk_timer.sv
module tdm_bclk_timer
   import tdm_mon_pkg::*;
#(
   parameter int NOM_TICKS = 12,
   parameter int TOL_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_seen,
   output logic fault
);

   localparam int LO_LIM = NOM_TICKS - TOL_TICKS;
   localparam int HI_LIM = NOM_TICKS + TOL_TICKS;
   localparam int GW     = bits_for(HI_LIM + 1);

   logic [GW-1:0] gap;
   logic          armed;
   logic          early_or_late;
   logic          stalled;

   // gap equals the distance in cycles to the previous edge when edge_seen
   assign early_or_late = armed && edge_seen &&
                          ((gap < GW'(LO_LIM)) || (gap > GW'(HI_LIM)));
   assign stalled       = armed && !edge_seen && (gap > GW'(HI_LIM));
   assign fault         = early_or_late || stalled;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap   <= '0;
         armed <= 1'b0;
      end else begin
         if (edge_seen) begin
            gap <= GW'(1);
         end else if (gap <= GW'(HI_LIM)) begin
            gap <= gap + GW'(1);
         end

         if (edge_seen) begin
            armed <= 1'b1;
         end else if (stalled) begin
            armed <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter
   import tdm_mon_pkg::*;
#(
   parameter int FRAME_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_edge,
   input  logic frame_edge,
   output logic fault,
   output logic good,
   output logic seen
);

   localparam int FW = bits_for(FRAME_CYCLES + 1);

   logic [FW-1:0] cnt;
   logic          armed;
   logic          overrun;
   logic          count_hit;

   assign count_hit = (cnt == FW'(FRAME_CYCLES));
   assign overrun   = armed && !frame_edge && bit_edge && count_hit;
   assign good      = armed && frame_edge && count_hit;
   assign fault     = (armed && frame_edge && !count_hit) || overrun;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         seen  <= 1'b0;
      end else if (frame_edge) begin
         cnt   <= bit_edge ? FW'(1) : FW'(0);
         armed <= 1'b1;
         seen  <= 1'b1;
      end else begin
         if (bit_edge && (cnt != FW'(FRAME_CYCLES + 1))) begin
            cnt <= cnt + FW'(1);
         end
         if (overrun) begin
            armed <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tdm_pair_monitor.sv
module tdm_pair_monitor
   import tdm_mon_pkg::*;
#(
   parameter int NOM_TICKS        = 12,
   parameter int TOL_TICKS        = 3,
   parameter int FRAME_CYCLES     = 1024,
   parameter int SYNC_STAGES      = 2,
   parameter bit FSYNC_ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_in,
   input  logic fsync_in,
   input  logic clr_clk_err,
   input  logic clr_frm_err,
   output logic clk_err,
   output logic frm_err,
   output logic pair_bad,
   output logic pair_valid
);

   if (NOM_TICKS < 2) begin : g_bad_nom
      $error("tdm_pair_monitor: NOM_TICKS must be at least 2");
   end
   if (TOL_TICKS < 0 || TOL_TICKS >= NOM_TICKS) begin : g_bad_tol
      $error("tdm_pair_monitor: TOL_TICKS must lie in 0..NOM_TICKS-1");
   end
   if (FRAME_CYCLES < 2) begin : g_bad_frame
      $error("tdm_pair_monitor: FRAME_CYCLES must be at least 2");
   end

   localparam logic [1:0] POL_MASK = {FSYNC_ACTIVE_LOW, 1'b0};

   logic [1:0] rises;
   logic       bclk_rise;
   logic       fs_rise;
   logic       frame_seen;
   logic       clean;
   logic       tmr_fault;
   mon_ev_t    ev;

   tdm_sync_rise #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (2),
      .INVERT (POL_MASK)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({fsync_in, bclk_in}),
      .rise  (rises)
   );

   assign bclk_rise = rises[0];
   assign fs_rise   = rises[1];

   tdm_bclk_timer #(
      .NOM_TICKS (NOM_TICKS),
      .TOL_TICKS (TOL_TICKS)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_seen (bclk_rise),
      .fault     (tmr_fault)
   );

   tdm_frame_counter #(
      .FRAME_CYCLES (FRAME_CYCLES)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_edge   (bclk_rise),
      .frame_edge (fs_rise),
      .fault      (ev.frm_fault),
      .good       (ev.frm_good),
      .seen       (frame_seen)
   );

   // Clock faults count only once framing has started
   assign ev.clk_fault = tmr_fault && frame_seen;

   // Sticky flags: a new fault wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_err <= 1'b0;
         frm_err <= 1'b0;
      end else begin
         if (ev.clk_fault)      clk_err <= 1'b1;
         else if (clr_clk_err)  clk_err <= 1'b0;
         if (ev.frm_fault)      frm_err <= 1'b1;
         else if (clr_frm_err)  frm_err <= 1'b0;
      end
   end

   // Live validity: needs one whole clean frame to come back
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pair_valid <= 1'b0;
         clean      <= 1'b0;
      end else begin
         if (ev.clk_fault || ev.frm_fault) begin
            pair_valid <= 1'b0;
         end else if (ev.frm_good && clean) begin
            pair_valid <= 1'b1;
         end

         if (fs_rise) begin
            clean <= !ev.clk_fault;
         end else if (ev.clk_fault) begin
            clean <= 1'b0;
         end
      end
   end

   assign pair_bad = clk_err | frm_err;

endmodule

// File: rtl/tdm_pair_monitor_chk.sv
module tdm_pair_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic clr_clk_err,
   input logic clr_frm_err,
   input logic clk_err,
   input logic frm_err,
   input logic pair_valid,
   input logic fs_rise,
   input logic frame_seen
);

   // R2
   quiet_before_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_seen |-> (!clk_err && !frm_err));

   // R7
   clk_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_err && !clr_clk_err) |=> clk_err);

   // R7
   frm_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_err && !clr_frm_err) |=> frm_err);

   // R9
   valid_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pair_valid) |-> $past(fs_rise));

   // R10
   clk_fault_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_err) |-> !pair_valid);

   // R10
   frm_fault_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_err) |-> !pair_valid);

endmodule

bind tdm_pair_monitor tdm_pair_monitor_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr_clk_err (clr_clk_err),
   .clr_frm_err (clr_frm_err),
   .clk_err     (clk_err),
   .frm_err     (frm_err),
   .pair_valid  (pair_valid),
   .fs_rise     (fs_rise),
   .frame_seen  (frame_seen)
);

// File: tb/sim_tdm_pair_monitor.sv
`timescale 1ns/100ps
module sim_tdm_pair_monitor;

   localparam int NOM = 15;   // 122 ns at 8 ns per tick
   localparam int TOL = 4;    // about 35 ns
   localparam int NF  = 32;   // shortened frame for run time

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk_in = 1'b0;
   logic fsync_in = 1'b0;
   logic clr_clk_err = 1'b0;
   logic clr_frm_err = 1'b0;
   logic clk_err, frm_err, pair_bad, pair_valid;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   tdm_pair_monitor #(
      .NOM_TICKS    (NOM),
      .TOL_TICKS    (TOL),
      .FRAME_CYCLES (NF)
   ) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk_in     (bclk_in),
      .fsync_in    (fsync_in),
      .clr_clk_err (clr_clk_err),
      .clr_frm_err (clr_frm_err),
      .clk_err     (clk_err),
      .frm_err     (frm_err),
      .pair_bad    (pair_bad),
      .pair_valid  (pair_valid)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic settle();
      @(negedge clk);
      #0.5;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bclk_in = 1'b0; fsync_in = 1'b0;
      clr_clk_err = 1'b0; clr_frm_err = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle();
   endtask

   task automatic bit_cyc(input real hi, input real lo, input logic fs);
      bclk_in = 1'b1;
      #(hi);
      bclk_in = 1'b0;
      fsync_in = fs;
      #(lo);
   endtask

   task automatic frame(input int nbits, input logic pulse_at_end);
      for (int i = 0; i < nbits; i++) begin
         bit_cyc(61.0, 61.0, pulse_at_end && (i == nbits - 1));
      end
   endtask

   // Two pulses with a correct frame between them
   task automatic lock();
      do_reset();
      frame(NF, 1'b1);
      frame(NF, 1'b1);
      settle();
      check("R9 valid after first full frame", pair_valid, 1'b1);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 clk_err", clk_err, 1'b0);
      check("R1 frm_err", frm_err, 1'b0);
      check("R1 pair_bad", pair_bad, 1'b0);
      check("R1 pair_valid", pair_valid, 1'b0);
   endtask

   task automatic t_pre_frame();
      do_reset();
      for (int i = 0; i < 6; i++) bit_cyc(30.0, 30.0, 1'b0);
      #300;
      settle();
      check("R2 clk_err before frame", clk_err, 1'b0);
      check("R2 frm_err before frame", frm_err, 1'b0);
      frame(5, 1'b1);
      bit_cyc(61.0, 61.0, 1'b0);
      settle();
      check("R2 partial first frame not judged", frm_err, 1'b0);
      check("R2 clk_err after first pulse", clk_err, 1'b0);
   endtask

   task automatic t_lock();
      lock();
      check("R9 no clk_err on clean bus", clk_err, 1'b0);
      check("R9 no frm_err on clean bus", frm_err, 1'b0);
      check("R8 pair_bad clear", pair_bad, 1'b0);
   endtask

   task automatic t_short_edge();
      lock();
      bit_cyc(30.0, 30.0, 1'b0);
      bit_cyc(61.0, 61.0, 1'b0);
      settle();
      check("R3 early edge sets clk_err", clk_err, 1'b1);
      check("R3 early edge leaves frm_err", frm_err, 1'b0);
      check("R10 valid drops on clock fault", pair_valid, 1'b0);
      check("R8 pair_bad follows clk_err", pair_bad, 1'b1);
   endtask

   task automatic t_long_edge();
      lock();
      bit_cyc(91.0, 91.0, 1'b0);
      bit_cyc(61.0, 61.0, 1'b0);
      settle();
      check("R3 late edge sets clk_err", clk_err, 1'b1);
   endtask

   task automatic t_stopped();
      lock();
      #300;
      settle();
      check("R4 stopped clock sets clk_err", clk_err, 1'b1);
      check("R4 stopped clock leaves frm_err", frm_err, 1'b0);
   endtask

   task automatic t_early_frame();
      lock();
      frame(NF - 3, 1'b1);
      bit_cyc(61.0, 61.0, 1'b0);
      settle();
      check("R5 early pulse sets frm_err", frm_err, 1'b1);
      check("R5 early pulse leaves clk_err", clk_err, 1'b0);
      check("R10 valid drops on frame fault", pair_valid, 1'b0);
      frame(NF - 1, 1'b1);
      settle();
      check("R9 valid returns after clean frame", pair_valid, 1'b1);
      check("R7 frm_err still sticky", frm_err, 1'b1);
   endtask

   task automatic t_missing_and_clear();
      lock();
      frame(NF + 3, 1'b0);
      settle();
      check("R6 missing pulse sets frm_err", frm_err, 1'b1);
      check("R6 missing pulse leaves clk_err", clk_err, 1'b0);
      #300;
      settle();
      check("R4 clk_err after stop", clk_err, 1'b1);
      @(negedge clk); clr_frm_err = 1'b1;
      @(negedge clk); clr_frm_err = 1'b0;
      settle();
      check("R7 clear removes frm_err", frm_err, 1'b0);
      check("R7 clear of frm keeps clk_err", clk_err, 1'b1);
      check("R8 pair_bad with clk_err only", pair_bad, 1'b1);
      @(negedge clk); clr_clk_err = 1'b1;
      @(negedge clk); clr_clk_err = 1'b0;
      settle();
      check("R7 clear removes clk_err", clk_err, 1'b0);
      check("R8 pair_bad clear after both cleared", pair_bad, 1'b0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(150000 * 8);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_pre_frame();
      t_lock();
      t_short_edge();
      t_long_edge();
      t_stopped();
      t_early_frame();
      t_missing_and_clear();
      finish_run();
   end

endmodule